// File: doc/BRIEF.md
# Prioritised Eight-Line Interrupt Controller

The controller combines eight interrupt request lines into a single interrupt signal for a host processor. Each line can be set to react to a rising edge or to follow a level. Pending requests are held in a request register. A mask register keeps chosen lines from being offered. An in-service register remembers which requests the host has accepted but not yet retired, so a request is offered only when it outranks everything currently in service. This allows nested handling of interrupts.

The host answers `int_req` with a one-cycle `int_ack` pulse. One cycle later the controller returns a vector on `vec_out` with `vec_valid` high. The vector is the programmed base with its low three bits replaced by the winning line number. If nothing is left to grant at acknowledge time, for example because a level line dropped early, the controller returns the line-7 vector and changes no state.

Priority is either fixed, with line 0 highest, or rotating, where the most recently retired line drops to the bottom. In-service bits are retired either by a non-specific end-of-interrupt command or automatically at acknowledge. A small write port programs the mask, the trigger type of each line, the vector base and the mode bits.

Top module: `pic_irq_ctrl`

## Requirements
- R1: After reset, `int_req` and `vec_valid` are low, all request, in-service and mask bits are clear, every line is edge-triggered, the base is 0, and both priority mode and end-of-interrupt mode are fixed/manual.
- R2: An edge-triggered line (trigger bit 0) sets its request on a rising edge. The request stays pending after the line falls, until it is granted.
- R3: A level-triggered line (trigger bit 1) has a request that follows the sampled input. If the line falls before acknowledge, the request disappears and the acknowledge is answered as spurious.
- R4: A line whose mask bit is 1 is never offered, but its pending request is kept. Clearing the mask bit offers it again.
- R5: In fixed mode, line 0 has the highest priority and line 7 the lowest.
- R6: Every `int_ack` pulse is followed in the next cycle by exactly one cycle of `vec_valid`. `vec_out` then equals `{base[7:3], line}`.
- R7: A grant moves the winning bit from the request register to the in-service register. `int_req` is high only while some unmasked pending request outranks every in-service bit.
- R8: Writing the control address (3) with data bit 7 set is a non-specific end-of-interrupt command. It clears only the highest-priority in-service bit and leaves the mode bits unchanged.
- R9: With automatic end-of-interrupt (control bit 1 = 1), a grant leaves no in-service bit set.
- R10: In rotating mode (control bit 0 = 1), the line whose in-service bit is retired becomes the lowest priority, and the line above it becomes the highest.
- R11: An acknowledge with no request to grant returns `{base[7:3], 3'd7}`, sets no in-service bit and consumes no request.
- R12: Write addresses are: 0 for the mask, 1 for the trigger type per line, 2 for the vector base (bits 7:3 kept), and 3 for control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 8 | Interrupt request lines, bit n is line n |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 2 | Configuration address (0 mask, 1 trigger, 2 base, 3 control) |
| cfg_wdata | input | 8 | Configuration write data |
| int_ack | input | 1 | One-cycle acknowledge from the host |
| int_req | output | 1 | Interrupt request to the host |
| vec_valid | output | 1 | Vector valid, one cycle after acknowledge |
| vec_out | output | 8 | Interrupt vector |

## Verification
The embedded properties check several rules on every cycle. Edge requests are held and level requests follow their input. Each acknowledge produces exactly one valid cycle. A grant lands in the in-service register unless automatic retirement is on. An end-of-interrupt removes exactly one in-service bit. A spurious acknowledge leaves the in-service set untouched.

Some behaviour spans several operations, and only the bench scenarios can show it. This covers which line wins under fixed and rotated orderings, nested preemption, masked requests returning after unmasking, and the vector numbers. The bench drives these sequences and compares each returned vector against a queue of expected values.

// File: rtl/pic_pkg.sv
package pic_pkg;

   typedef enum logic [1:0] {
      CFG_MASK = 2'd0,
      CFG_TRIG = 2'd1,
      CFG_BASE = 2'd2,
      CFG_CTRL = 2'd3
   } cfg_sel_e;

   localparam int CTRL_ROTATE_BIT = 0;
   localparam int CTRL_AUTO_BIT   = 1;
   localparam int CTRL_EOI_BIT    = 7;

endpackage

// File: rtl/pic_req_capture.sv
module pic_req_capture #(
   parameter int LINES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] irq_in,
   input  logic [LINES-1:0] level_sel,
   input  logic [LINES-1:0] clr,
   output logic [LINES-1:0] irr
);

   logic [LINES-1:0] prev_q;
   logic [LINES-1:0] irr_q;

   for (genvar i = 0; i < LINES; i++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q[i] <= 1'b0;
            irr_q[i]  <= 1'b0;
         end else begin
            prev_q[i] <= irq_in[i];
            if (level_sel[i])
               irr_q[i] <= irq_in[i] & ~clr[i];
            else
               irr_q[i] <= (irr_q[i] & ~clr[i]) | (irq_in[i] & ~prev_q[i]);
         end
      end

      // R2: an edge request is held until it is granted
      p_edge_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (!level_sel[i] && irr_q[i] && !clr[i]) |=> irr_q[i]);

      // R3: a level request tracks the sampled input
      p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (level_sel[i] && !clr[i]) |=> (irr_q[i] == $past(irq_in[i])));
   end

   assign irr = irr_q;

endmodule

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
   parameter int LINES = 8,
   localparam int IDW = $clog2(LINES)
) (
   input  logic [LINES-1:0] req,
   input  logic [IDW-1:0]   low_ptr,
   output logic             any,
   output logic [IDW-1:0]   idx,
   output logic [IDW-1:0]   rank
);

   always_comb begin
      logic [IDW-1:0] cand;
      any  = 1'b0;
      idx  = '0;
      rank = '0;
      cand = '0;
      // walk from lowest priority upward so the highest one is kept last
      for (int k = LINES - 1; k >= 0; k--) begin
         cand = low_ptr + IDW'(k + 1);
         if (req[cand]) begin
            any  = 1'b1;
            idx  = cand;
            rank = IDW'(k);
         end
      end
   end

endmodule

// File: rtl/pic_irq_ctrl.sv
module pic_irq_ctrl #(
   parameter int LINES     = 8,
   parameter int DATA_W    = 8,
   parameter bit ROTATE_EN = 1'b1,
   localparam int IDW      = $clog2(LINES),
   localparam int BASE_W   = DATA_W - IDW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINES-1:0]  irq_in,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              int_ack,
   output logic              int_req,
   output logic              vec_valid,
   output logic [DATA_W-1:0] vec_out
);
   import pic_pkg::*;

   initial begin
      assert (LINES >= 2 && (1 << IDW) == LINES)
         else $fatal(1, "LINES must be a power of two, at least 2");
      assert (LINES <= DATA_W)
         else $fatal(1, "LINES must fit in DATA_W");
      assert (DATA_W >= CTRL_EOI_BIT + 1)
         else $fatal(1, "DATA_W too narrow for control bits");
   end

   localparam logic [LINES-1:0] ONE_HOT0 = LINES'(1);
   localparam logic [IDW-1:0]   LAST_ID  = IDW'(LINES - 1);

   logic [LINES-1:0]  mask_q, trig_q, isr_q, irr;
   logic [BASE_W-1:0] base_q;
   logic              auto_q;
   logic              vld_q;
   logic [DATA_W-1:0] vec_q;
   logic [IDW-1:0]    eff_ptr;

   cfg_sel_e cfg_sel;
   logic     eoi_cmd, mode_wr;
   assign cfg_sel = cfg_sel_e'(cfg_addr);
   assign eoi_cmd = cfg_we && (cfg_sel == CFG_CTRL) && cfg_wdata[CTRL_EOI_BIT];
   assign mode_wr = cfg_we && (cfg_sel == CFG_CTRL) && !cfg_wdata[CTRL_EOI_BIT];

   // request capture
   logic [LINES-1:0] ack_clr;
   pic_req_capture #(.LINES(LINES)) u_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_in   (irq_in),
      .level_sel(trig_q),
      .clr      (ack_clr),
      .irr      (irr)
   );

   // priority resolution for pending and in-service sets
   logic           req_any, isr_any;
   logic [IDW-1:0] win_idx, win_rank, isr_idx, isr_rank;

   pic_prio_pick #(.LINES(LINES)) u_pick_req (
      .req    (irr & ~mask_q),
      .low_ptr(eff_ptr),
      .any    (req_any),
      .idx    (win_idx),
      .rank   (win_rank)
   );

   pic_prio_pick #(.LINES(LINES)) u_pick_isr (
      .req    (isr_q),
      .low_ptr(eff_ptr),
      .any    (isr_any),
      .idx    (isr_idx),
      .rank   (isr_rank)
   );

   assign int_req = req_any && (!isr_any || (win_rank < isr_rank));

   logic grant;
   logic [LINES-1:0] eoi_clr, isr_set;
   assign grant   = int_ack && int_req;
   assign ack_clr = grant ? (ONE_HOT0 << win_idx) : '0;
   assign isr_set = (grant && !auto_q) ? (ONE_HOT0 << win_idx) : '0;
   assign eoi_clr = (eoi_cmd && isr_any) ? (ONE_HOT0 << isr_idx) : '0;

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         trig_q <= '0;
         base_q <= '0;
         auto_q <= 1'b0;
      end else if (cfg_we) begin
         unique case (cfg_sel)
            CFG_MASK: mask_q <= cfg_wdata[LINES-1:0];
            CFG_TRIG: trig_q <= cfg_wdata[LINES-1:0];
            CFG_BASE: base_q <= cfg_wdata[DATA_W-1:IDW];
            CFG_CTRL: if (mode_wr) auto_q <= cfg_wdata[CTRL_AUTO_BIT];
         endcase
      end
   end

   // in-service register and vector output
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         isr_q <= '0;
         vld_q <= 1'b0;
         vec_q <= '0;
      end else begin
         isr_q <= (isr_q & ~eoi_clr) | isr_set;
         vld_q <= int_ack;
         if (int_ack)
            vec_q <= {base_q, (grant ? win_idx : LAST_ID)};
      end
   end

   // priority pointer variant
   if (ROTATE_EN) begin : g_rotate
      logic           rot_q;
      logic [IDW-1:0] ptr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rot_q <= 1'b0;
            ptr_q <= LAST_ID;
         end else begin
            if (mode_wr)
               rot_q <= cfg_wdata[CTRL_ROTATE_BIT];
            if (rot_q && eoi_cmd && isr_any)
               ptr_q <= isr_idx;
            else if (rot_q && grant && auto_q)
               ptr_q <= win_idx;
         end
      end
      assign eff_ptr = rot_q ? ptr_q : LAST_ID;
   end else begin : g_fixed
      assign eff_ptr = LAST_ID;
   end

   assign vec_valid = vld_q;
   assign vec_out   = vec_q;

   // R6: one valid cycle per acknowledge, nothing otherwise
   p_ack_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      int_ack |=> vec_valid);
   p_no_ack_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !int_ack |=> !vec_valid);

   // R7: a manual-mode grant lands in the in-service register
   p_grant_to_isr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && int_req && !auto_q) |=> isr_q[$past(win_idx)]);

   // R8: an end-of-interrupt command removes exactly one in-service bit
   p_eoi_one_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_cmd && isr_q != '0 && !int_ack) |=>
         ($countones(isr_q) == $countones($past(isr_q)) - 1));

   // R9: automatic retirement never adds in-service bits
   p_auto_no_isr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      auto_q |=> ((isr_q & ~$past(isr_q)) == '0));

   // R11: a spurious acknowledge answers with the last line and keeps state
   p_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && !int_req && !eoi_cmd) |=>
         ((vec_out[IDW-1:0] == LAST_ID) && $stable(isr_q)));

endmodule

// File: tb/tb_pic_irq_ctrl.sv
module tb_pic_irq_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq = '0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic       int_ack = 1'b0;
   logic       int_req, vec_valid;
   logic [7:0] vec_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [7:0] mode = '0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #4 clk = ~clk;

   pic_irq_ctrl dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_in   (irq),
      .cfg_we   (cfg_we),
      .cfg_addr (cfg_addr),
      .cfg_wdata(cfg_wdata),
      .int_ack  (int_ack),
      .int_req  (int_req),
      .vec_valid(vec_valid),
      .vec_out  (vec_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor: pops expected vectors as the design presents them
   always @(negedge clk) begin
      if (rst_n && vec_valid) begin
         if (exp_q.size() == 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R6: actual unexpected vector %0h expected none", vec_out);
         end else begin
            chk(tag_q.pop_front(), vec_out, exp_q.pop_front());
         end
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_mode(input logic [7:0] m);
      mode = m;
      wr(2'd3, m);
   endtask

   task automatic eoi();
      wr(2'd3, 8'h80 | mode);
   endtask

   task automatic pulse(input logic [7:0] lines);
      @(negedge clk);
      irq = irq | lines;
      @(negedge clk);
      irq = irq & ~lines;
   endtask

   // driver: acknowledge and push the expected vector
   task automatic ack(input logic [7:0] exp, input string tag);
      @(negedge clk);
      int_ack = 1'b1;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      int_ack = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 8);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 int_req", int_req, 0);
      chk("R1 vec_valid", vec_valid, 0);

      // R11: nothing pending, base 0
      ack(8'h07, "R11 spurious at reset");
      chk("R11 no request after spurious", int_req, 0);

      // R12: base register
      wr(2'd2, 8'h40);

      // R2 / R5: two edges, lines dropped
      pulse(8'b0010_0100);
      chk("R2 held after drop", int_req, 1);
      repeat (2) @(negedge clk);
      chk("R2 still held", int_req, 1);
      ack(8'h42, "R5 line 2 beats 5");
      chk("R7 lower blocked by in-service", int_req, 0);
      pulse(8'b0000_0010);
      chk("R7 higher preempts", int_req, 1);
      ack(8'h41, "R6 nested vector");
      eoi();
      chk("R8 line 5 still blocked by 2", int_req, 0);
      pulse(8'b0000_0010);
      chk("R8 line 1 retired first", int_req, 1);
      ack(8'h41, "R8 line 1 again");
      eoi();
      eoi();
      chk("R7 line 5 offered once clear", int_req, 1);
      ack(8'h45, "R6 line 5");
      eoi();
      chk("R7 idle", int_req, 0);

      // R4: mask
      wr(2'd0, 8'h08);
      pulse(8'b0000_1000);
      chk("R4 masked not offered", int_req, 0);
      ack(8'h47, "R11 spurious with masked pending");
      wr(2'd0, 8'h00);
      chk("R4 unmask offers kept request", int_req, 1);
      ack(8'h43, "R4 line 3");
      eoi();
      pulse(8'b1000_0000);
      chk("R11 spurious set no in-service 7", int_req, 1);
      ack(8'h47, "R11 real line 7");
      eoi();

      // R3: level line
      wr(2'd1, 8'h10);
      @(negedge clk); irq[4] = 1'b1;
      @(negedge clk);
      chk("R3 level raises request", int_req, 1);
      irq[4] = 1'b0;
      @(negedge clk);
      chk("R3 level drop clears request", int_req, 0);
      ack(8'h47, "R3 early drop gives spurious");
      irq[4] = 1'b1;
      @(negedge clk);
      ack(8'h44, "R3 level grant");
      chk("R3 in-service blocks same line", int_req, 0);
      eoi();
      chk("R3 level re-requests after eoi", int_req, 1);
      irq[4] = 1'b0;
      @(negedge clk);
      chk("R3 level drop again", int_req, 0);
      wr(2'd1, 8'h00);

      // R9: automatic end of interrupt
      set_mode(8'h02);
      pulse(8'b0000_1000);
      ack(8'h43, "R9 auto grant");
      pulse(8'b0100_0000);
      chk("R9 nothing in service", int_req, 1);
      ack(8'h46, "R9 lower line follows");

      // R10: rotating priority
      set_mode(8'h01);
      pulse(8'b0000_0110);
      ack(8'h41, "R10 before rotation");
      eoi();
      pulse(8'b0000_0001);
      ack(8'h42, "R10 line 1 rotated to bottom");
      eoi();
      ack(8'h40, "R10 line 0 last");
      eoi();
      pulse(8'b1000_0010);
      ack(8'h41, "R10 line 1 top after 0");
      eoi();
      ack(8'h47, "R10 line 7");
      eoi();
      chk("R10 idle", int_req, 0);

      repeat (3) @(negedge clk);
      chk("R6 all vectors returned", exp_q.size(), 0);
      finish_run();
   end

endmodule